// File: doc/BRIEF.md
# Command and Interrupt Register File

This block is the host-visible control core of a network controller. It keeps the 16-bit command, configuration, control and interrupt registers behind a plain word-wide write port with a combinational read port. A host write to the command register turns each command bit into a single-cycle action strobe for the engines around it: halt transmit, transmit, receiver disable, receiver enable, timer stop, timer start, software reset, read resource and load address table. Pending command bits stay set until the engine reports completion on `engine_cmd_done`. Engines report events through `engine_status_set`, and the block drives one level interrupt from the unmasked status bits.

The command register is built around a two-state mode machine. `MODE_RESET` means the software reset bit is set. `MODE_RUN` is normal operation. There are two transitions. *Release* goes from `MODE_RESET` to `MODE_RUN` on a command write whose bit 7 is zero, and that write has no other effect. *Enter reset* goes to `MODE_RESET` on any command write with bit 7 set. A hardware reset also forces `MODE_RESET`. In `MODE_RESET` the two configuration registers accept writes. In `MODE_RUN` they are locked.

Each register has its own write rule: reset-only, masked with read-only fields, or write-1-to-clear. Writes to unused addresses are dropped.

Top module: `netctl_regfile`

## Requirements
- R1: The command register lives at address 0 and has these bits: 0 halt transmit, 1 transmit, 2 receiver disable, 3 receiver enable, 4 timer stop, 5 timer start, 7 software reset, 8 read resource, 9 load table. Only bits in 0x03BF are stored. For an accepted command write, each of those bits that is set in the write data produces a one-cycle strobe. The strobe is high in the cycle after the write edge, and the new register value is readable from the same point.
- R2: While bit 7 reads as 1, a command write with bit 7 clear only clears bit 7. It stores nothing else and raises no strobe.
- R3: Writing bit 3 clears bit 2, writing bit 2 clears bit 3, writing bit 5 clears bit 4, and writing bit 4 clears bit 5. The clears are applied in that order after the written bits are OR-ed in. As a result, writing both bits of a pair leaves both bits clear.
- R4: A command write with bit 7 set clears bits 0, 1, 8 and 9, and then sets bits 7 and 2.
- R5: The status register at address 2 sets bits from `engine_status_set`. A host write of 1 clears only those bits that are currently set. An engine set wins over a host clear of the same bit in the same cycle.
- R6: The mask register at address 1 stores write data AND 0x7FFF. `irq` is high whenever mask AND status is nonzero, and it changes on the same edge as the registers it depends on.
- R7: The data configuration register at address 5 (mask 0xBFFF) and the second configuration register at address 6 (mask 0xF017) accept writes only while command bit 7 is 1.
- R8: In the transmit control register at address 3, bits 11:0 ignore host writes. In the receive control register at address 4, bits 8:0 ignore host writes. Both registers reset to zero.
- R9: Hardware reset gives these values: command 0x0094, mask 0, status 0, both configuration registers 0, and the end-of-buffer count at address 7 set to 0x02F8. The end-of-buffer count is fully writable.
- R10: A host write that clears status bit 5 also raises the read-resource strobe in the next cycle.
- R11: Each bit set in `engine_cmd_done` clears the matching stored command bit (bit 7 excepted) on the next edge.
- R12: Addresses 8 and above read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| host_we | input | 1 | Host write enable |
| host_addr | input | 6 | Register word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for `host_addr` (combinational) |
| engine_cmd_done | input | 16 | Completion: clears pending command bits |
| engine_status_set | input | 16 | Event bits OR-ed into status |
| stb_halt_tx | output | 1 | Halt transmit strobe |
| stb_tx_start | output | 1 | Transmit strobe |
| stb_rx_disable | output | 1 | Receiver disable strobe |
| stb_rx_enable | output | 1 | Receiver enable strobe |
| stb_timer_stop | output | 1 | Timer stop strobe |
| stb_timer_start | output | 1 | Timer start strobe |
| stb_soft_reset | output | 1 | Software reset strobe |
| stb_read_rsrc | output | 1 | Read resource strobe |
| stb_load_cam | output | 1 | Load address table strobe |
| irq | output | 1 | Level interrupt |

## Verification
Every effect of a write or an engine input is due exactly one clock edge later: strobes, `irq` and the register contents all register on that edge. The read port adds no delay after that. The bench drives each operation on a falling edge and returns inputs to idle on the next falling edge. At that second falling edge it checks the strobes and `irq`, which are valid only in that single cycle. It then sweeps the read address to compare every register against its model, while writes are idle so nothing can move.

// File: rtl/netctl_regs_pkg.sv
package netctl_regs_pkg;

    // register word addresses
    localparam int unsigned ADR_CMD   = 0;
    localparam int unsigned ADR_IMASK = 1;
    localparam int unsigned ADR_ISTAT = 2;
    localparam int unsigned ADR_TXCTL = 3;
    localparam int unsigned ADR_RXCTL = 4;
    localparam int unsigned ADR_DCFG  = 5;
    localparam int unsigned ADR_DCFG2 = 6;
    localparam int unsigned ADR_EOB   = 7;

    // command bit positions
    localparam int unsigned B_HALT   = 0;
    localparam int unsigned B_TX     = 1;
    localparam int unsigned B_RXDIS  = 2;
    localparam int unsigned B_RXEN   = 3;
    localparam int unsigned B_TSTOP  = 4;
    localparam int unsigned B_TSTART = 5;
    localparam int unsigned B_RST    = 7;
    localparam int unsigned B_RRSC   = 8;
    localparam int unsigned B_LCAM   = 9;

    // command bits kept in the bit register (reset bit lives in the mode FSM)
    localparam logic [15:0] CMD_STORE_MASK = 16'h033F;
    localparam logic [15:0] CMD_RESET_BITS = 16'h0014;

    // per-register write masks
    localparam logic [15:0] IMASK_WMASK = 16'h7FFF;
    localparam logic [15:0] TXCTL_WMASK = 16'hF000;
    localparam logic [15:0] RXCTL_WMASK = 16'hFE00;
    localparam logic [15:0] DCFG_WMASK  = 16'hBFFF;
    localparam logic [15:0] DCFG2_WMASK = 16'hF017;
    localparam logic [15:0] EOB_RESET   = 16'h02F8;

    localparam int unsigned ISTAT_RSRC_BIT = 5;

    typedef enum logic {
        MODE_RESET = 1'b0,
        MODE_RUN   = 1'b1
    } cmd_mode_e;

    typedef struct packed {
        logic load_cam;
        logic read_rsrc;
        logic soft_reset;
        logic timer_start;
        logic timer_stop;
        logic rx_enable;
        logic rx_disable;
        logic tx_start;
        logic halt_tx;
    } cmd_stb_t;

endpackage

// File: rtl/netctl_cmd_unit.sv
module netctl_cmd_unit
    import netctl_regs_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] done,
    output logic [DW-1:0] cmd_value,
    output logic          in_reset,
    output cmd_stb_t      stb
);

    localparam logic [DW-1:0] STORE_M = DW'(CMD_STORE_MASK);
    localparam logic [DW-1:0] RST_V   = DW'(CMD_RESET_BITS);

    cmd_mode_e     mode_q, mode_d;
    logic [DW-1:0] bits_q, bits_d;
    cmd_stb_t      stb_q, stb_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_RESET;
        else        mode_q <= mode_d;
    end

    // command bits and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= RST_V;
            stb_q  <= '0;
        end else begin
            bits_q <= bits_d;
            stb_q  <= stb_d;
        end
    end

    function automatic cmd_stb_t decode_stb(input logic [DW-1:0] d);
        cmd_stb_t s;
        s.halt_tx     = d[B_HALT];
        s.tx_start    = d[B_TX];
        s.rx_disable  = d[B_RXDIS];
        s.rx_enable   = d[B_RXEN];
        s.timer_stop  = d[B_TSTOP];
        s.timer_start = d[B_TSTART];
        s.soft_reset  = d[B_RST];
        s.read_rsrc   = d[B_RRSC];
        s.load_cam    = d[B_LCAM];
        return s;
    endfunction

    // next state, next bits and strobes
    always_comb begin
        mode_d = mode_q;
        bits_d = bits_q & ~(done & STORE_M);
        stb_d  = '0;
        if (wr_en) begin
            unique case (mode_q)
                MODE_RESET: begin
                    if (!wdata[B_RST]) begin
                        mode_d = MODE_RUN;           // release
                    end else begin
                        bits_d = bits_d | (wdata & STORE_M);
                        stb_d  = decode_stb(wdata);
                    end
                end
                MODE_RUN: begin
                    bits_d = bits_d | (wdata & STORE_M);
                    stb_d  = decode_stb(wdata);
                    if (wdata[B_RST]) mode_d = MODE_RESET; // enter reset
                end
                default: mode_d = MODE_RESET;
            endcase
            if (stb_d.rx_disable)  bits_d[B_RXEN]   = 1'b0;
            if (stb_d.rx_enable)   bits_d[B_RXDIS]  = 1'b0;
            if (stb_d.timer_stop)  bits_d[B_TSTART] = 1'b0;
            if (stb_d.timer_start) bits_d[B_TSTOP]  = 1'b0;
            if (stb_d.soft_reset) begin
                bits_d[B_LCAM]  = 1'b0;
                bits_d[B_RRSC]  = 1'b0;
                bits_d[B_TX]    = 1'b0;
                bits_d[B_HALT]  = 1'b0;
                bits_d[B_RXDIS] = 1'b1;
            end
        end
    end

    always_comb begin
        cmd_value        = bits_q;
        cmd_value[B_RST] = (mode_q == MODE_RESET);
    end

    assign in_reset = (mode_q == MODE_RESET);
    assign stb      = stb_q;

endmodule

// File: rtl/netctl_irq_unit.sv
module netctl_irq_unit
    import netctl_regs_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_we,
    input  logic          stat_we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] set_in,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] stat_q,
    output logic          irq,
    output logic          rsrc_pulse
);

    localparam logic [DW-1:0] MASK_M = DW'(IMASK_WMASK);

    logic [DW-1:0] mask_d, stat_d, clr;
    logic          irq_q, pulse_q;

    always_comb begin
        clr    = stat_we ? (wdata & stat_q) : '0;
        stat_d = (stat_q & ~clr) | set_in;
        mask_d = mask_we ? (wdata & MASK_M) : mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            stat_q  <= '0;
            irq_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            mask_q  <= mask_d;
            stat_q  <= stat_d;
            irq_q   <= |(mask_d & stat_d);
            pulse_q <= clr[ISTAT_RSRC_BIT];
        end
    end

    assign irq        = irq_q;
    assign rsrc_pulse = pulse_q;

endmodule

// File: rtl/netctl_masked_reg.sv
module netctl_masked_reg #(
    parameter int unsigned   DW         = 16,
    parameter logic [DW-1:0] WMASK      = '1,
    parameter logic [DW-1:0] RESET_VAL  = '0,
    parameter bit            RESET_ONLY = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          unlocked,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    logic accept;

    generate
        if (RESET_ONLY) begin : g_locked
            assign accept = we & unlocked;
        end else begin : g_open
            logic unused_unlocked;
            assign unused_unlocked = unlocked;
            assign accept = we;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= RESET_VAL;
        else if (accept) q <= (q & ~WMASK) | (wdata & WMASK);
    end

endmodule

// File: rtl/netctl_regfile.sv
module netctl_regfile
    import netctl_regs_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    input  logic [DW-1:0]     engine_cmd_done,
    input  logic [DW-1:0]     engine_status_set,
    output logic              stb_halt_tx,
    output logic              stb_tx_start,
    output logic              stb_rx_disable,
    output logic              stb_rx_enable,
    output logic              stb_timer_stop,
    output logic              stb_timer_start,
    output logic              stb_soft_reset,
    output logic              stb_read_rsrc,
    output logic              stb_load_cam,
    output logic              irq
);

    localparam int unsigned NREG = 8;

    logic [NREG-1:0] sel;
    logic [DW-1:0]   cmd_value, imr_q, isr_q, tcr_q, rcr_q, dcr_q, dcr2_q, eob_q;
    logic            in_reset, rsrc_pulse;
    cmd_stb_t        stb;

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_dec
            assign sel[gi] = host_we && (host_addr == ADDR_W'(gi));
        end
    endgenerate

    netctl_cmd_unit #(.DW(DW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_en(sel[ADR_CMD]), .wdata(host_wdata),
        .done(engine_cmd_done), .cmd_value(cmd_value), .in_reset(in_reset),
        .stb(stb)
    );

    netctl_irq_unit #(.DW(DW)) u_irq (
        .clk(clk), .rst_n(rst_n), .mask_we(sel[ADR_IMASK]),
        .stat_we(sel[ADR_ISTAT]), .wdata(host_wdata),
        .set_in(engine_status_set), .mask_q(imr_q), .stat_q(isr_q),
        .irq(irq), .rsrc_pulse(rsrc_pulse)
    );

    netctl_masked_reg #(.DW(DW), .WMASK(DW'(TXCTL_WMASK)), .RESET_VAL('0),
                        .RESET_ONLY(1'b0)) u_tcr (
        .clk(clk), .rst_n(rst_n), .we(sel[ADR_TXCTL]), .unlocked(in_reset),
        .wdata(host_wdata), .q(tcr_q));

    netctl_masked_reg #(.DW(DW), .WMASK(DW'(RXCTL_WMASK)), .RESET_VAL('0),
                        .RESET_ONLY(1'b0)) u_rcr (
        .clk(clk), .rst_n(rst_n), .we(sel[ADR_RXCTL]), .unlocked(in_reset),
        .wdata(host_wdata), .q(rcr_q));

    netctl_masked_reg #(.DW(DW), .WMASK(DW'(DCFG_WMASK)), .RESET_VAL('0),
                        .RESET_ONLY(1'b1)) u_dcr (
        .clk(clk), .rst_n(rst_n), .we(sel[ADR_DCFG]), .unlocked(in_reset),
        .wdata(host_wdata), .q(dcr_q));

    netctl_masked_reg #(.DW(DW), .WMASK(DW'(DCFG2_WMASK)), .RESET_VAL('0),
                        .RESET_ONLY(1'b1)) u_dcr2 (
        .clk(clk), .rst_n(rst_n), .we(sel[ADR_DCFG2]), .unlocked(in_reset),
        .wdata(host_wdata), .q(dcr2_q));

    netctl_masked_reg #(.DW(DW), .WMASK('1), .RESET_VAL(DW'(EOB_RESET)),
                        .RESET_ONLY(1'b0)) u_eob (
        .clk(clk), .rst_n(rst_n), .we(sel[ADR_EOB]), .unlocked(in_reset),
        .wdata(host_wdata), .q(eob_q));

    always_comb begin
        host_rdata = '0;
        if (host_addr < ADDR_W'(NREG)) begin
            case (host_addr[2:0])
                3'(ADR_CMD):   host_rdata = cmd_value;
                3'(ADR_IMASK): host_rdata = imr_q;
                3'(ADR_ISTAT): host_rdata = isr_q;
                3'(ADR_TXCTL): host_rdata = tcr_q;
                3'(ADR_RXCTL): host_rdata = rcr_q;
                3'(ADR_DCFG):  host_rdata = dcr_q;
                3'(ADR_DCFG2): host_rdata = dcr2_q;
                default:       host_rdata = eob_q;
            endcase
        end
    end

    assign stb_halt_tx     = stb.halt_tx;
    assign stb_tx_start    = stb.tx_start;
    assign stb_rx_disable  = stb.rx_disable;
    assign stb_rx_enable   = stb.rx_enable;
    assign stb_timer_stop  = stb.timer_stop;
    assign stb_timer_start = stb.timer_start;
    assign stb_soft_reset  = stb.soft_reset;
    assign stb_read_rsrc   = stb.read_rsrc | rsrc_pulse;
    assign stb_load_cam    = stb.load_cam;

endmodule

// File: rtl/netctl_regfile_chk.sv
module netctl_regfile_chk
    import netctl_regs_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DW-1:0]     host_wdata,
    input logic [DW-1:0]     engine_status_set,
    input logic [DW-1:0]     cmd_value,
    input logic [DW-1:0]     imr,
    input logic [DW-1:0]     isr,
    input logic [DW-1:0]     dcr,
    input logic [DW-1:0]     tcr,
    input logic [8:0]        stb_all,
    input logic              stb_read_rsrc,
    input logic              irq
);

    logic wr_cmd, wr_isr, wr_dcr, wr_tcr;
    assign wr_cmd = host_we && (host_addr == ADDR_W'(ADR_CMD));
    assign wr_isr = host_we && (host_addr == ADDR_W'(ADR_ISTAT));
    assign wr_dcr = host_we && (host_addr == ADDR_W'(ADR_DCFG));
    assign wr_tcr = host_we && (host_addr == ADDR_W'(ADR_TXCTL));

    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd && cmd_value[B_RST] && !host_wdata[B_RST]
        |=> !cmd_value[B_RST] && (stb_all == '0));

    p_rx_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd && host_wdata[B_RXEN] && !host_wdata[B_RXDIS]
        && !host_wdata[B_RST] && !cmd_value[B_RST]
        |=> cmd_value[B_RXEN] && !cmd_value[B_RXDIS]);

    p_soft_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd && host_wdata[B_RST]
        |=> cmd_value[B_RST] && cmd_value[B_RXDIS] && !cmd_value[B_LCAM]
            && !cmd_value[B_RRSC] && !cmd_value[B_TX] && !cmd_value[B_HALT]);

    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_isr && (engine_status_set == '0)
        |=> isr == ($past(isr) & ~$past(host_wdata)));

    p_status_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_isr |=> ((isr & $past(isr)) == $past(isr)));

    p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(imr & isr)));

    p_mask_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !imr[DW-1]);

    p_cfg_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dcr && !cmd_value[B_RST] |=> $stable(dcr));

    p_tx_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tcr |=> tcr == ($past(host_wdata) & DW'(TXCTL_WMASK)));

    p_rsrc_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_isr && host_wdata[ISTAT_RSRC_BIT] && isr[ISTAT_RSRC_BIT]
        |=> stb_read_rsrc);

endmodule

bind netctl_regfile netctl_regfile_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .engine_status_set(engine_status_set),
    .cmd_value(cmd_value), .imr(imr_q), .isr(isr_q), .dcr(dcr_q), .tcr(tcr_q),
    .stb_all({stb_load_cam, stb_read_rsrc, stb_soft_reset, stb_timer_start,
              stb_timer_stop, stb_rx_enable, stb_rx_disable, stb_tx_start,
              stb_halt_tx}),
    .stb_read_rsrc(stb_read_rsrc), .irq(irq)
);

// File: tb/tb_netctl_regfile.sv
`timescale 1ns/1ps
module tb_netctl_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [15:0] engine_cmd_done = '0;
    logic [15:0] engine_status_set = '0;
    logic s_halt, s_tx, s_rxd, s_rxe, s_tstop, s_tstart, s_rst, s_rrsc, s_lcam;
    logic irq;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    netctl_regfile dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .engine_cmd_done(engine_cmd_done), .engine_status_set(engine_status_set),
        .stb_halt_tx(s_halt), .stb_tx_start(s_tx), .stb_rx_disable(s_rxd),
        .stb_rx_enable(s_rxe), .stb_timer_stop(s_tstop),
        .stb_timer_start(s_tstart), .stb_soft_reset(s_rst),
        .stb_read_rsrc(s_rrsc), .stb_load_cam(s_lcam), .irq(irq)
    );

    // model state
    logic [15:0] m_cmd, m_imr, m_isr, m_tcr, m_rcr, m_dcr, m_dcr2, m_eob;
    logic [8:0]  e_stb;

    task automatic model_reset();
        m_cmd = 16'h0094; m_imr = 0; m_isr = 0; m_tcr = 0; m_rcr = 0;
        m_dcr = 0; m_dcr2 = 0; m_eob = 16'h02F8;
    endtask

    function automatic logic [15:0] model_read(input logic [5:0] a);
        case (a)
            6'd0: return m_cmd;  6'd1: return m_imr;
            6'd2: return m_isr;  6'd3: return m_tcr;
            6'd4: return m_rcr;  6'd5: return m_dcr;
            6'd6: return m_dcr2; 6'd7: return m_eob;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_step(input logic we, input logic [5:0] a,
                              input logic [15:0] d, input logic [15:0] done,
                              input logic [15:0] sset);
        logic [15:0] c, wc;
        logic rr;
        c = m_cmd & ~(done & 16'h033F);
        e_stb = '0;
        rr = 1'b0;
        if (we && a == 6'd0) begin
            if (m_cmd[7] && !d[7]) c[7] = 1'b0;
            else begin
                c = c | (d & 16'h033F);
                if (d[2]) c[3] = 1'b0;
                if (d[3]) c[2] = 1'b0;
                if (d[4]) c[5] = 1'b0;
                if (d[5]) c[4] = 1'b0;
                if (d[7]) begin
                    c[9] = 0; c[8] = 0; c[1] = 0; c[0] = 0; c[7] = 1; c[2] = 1;
                end
                e_stb = {d[9], d[8], d[7], d[5], d[4], d[3], d[2], d[1], d[0]};
            end
        end
        if (we && a == 6'd5 && m_cmd[7]) m_dcr  = d & 16'hBFFF;
        if (we && a == 6'd6 && m_cmd[7]) m_dcr2 = d & 16'hF017;
        if (we && a == 6'd3) m_tcr = d & 16'hF000;
        if (we && a == 6'd4) m_rcr = d & 16'hFE00;
        if (we && a == 6'd7) m_eob = d;
        if (we && a == 6'd1) m_imr = d & 16'h7FFF;
        if (we && a == 6'd2) begin
            wc = d & m_isr;
            rr = wc[5];
            m_isr = (m_isr & ~wc) | sset;
        end else begin
            m_isr = m_isr | sset;
        end
        e_stb[7] = e_stb[7] | rr;
        m_cmd = c;
    endtask

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all_regs(input string req);
        for (int a = 0; a < 8; a++) begin
            host_addr = 6'(a);
            #0.4;
            check($sformatf("%s reg%0d", req, a), host_rdata, model_read(6'(a)));
        end
        host_addr = 6'd8;
        #0.4;
        check("R12 read undefined 8", host_rdata, 16'h0);
        host_addr = 6'd63;
        #0.4;
        check("R12 read undefined 63", host_rdata, 16'h0);
    endtask

    // one operation: drive at falling edge, check at the next falling edge
    task automatic op(input string req, input logic we, input logic [5:0] a,
                      input logic [15:0] d, input logic [15:0] done,
                      input logic [15:0] sset);
        @(negedge clk);
        host_we = we; host_addr = a; host_wdata = d;
        engine_cmd_done = done; engine_status_set = sset;
        model_step(we, a, d, done, sset);
        @(negedge clk);
        host_we = 1'b0; engine_cmd_done = '0; engine_status_set = '0;
        check({req, " R1 strobes"},
              16'({s_lcam, s_rrsc, s_rst, s_tstart, s_tstop, s_rxe, s_rxd, s_tx, s_halt}),
              16'(e_stb));
        check({req, " R6 irq"}, 16'(irq), 16'(|(m_imr & m_isr)));
        check_all_regs(req);
    endtask

    initial begin
        logic [31:0] seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all_regs("R9 reset values");
        check("R6 irq after reset", 16'(irq), 16'h0);

        // directed corner cases
        op("R7 config write in reset", 1, 6'd5, 16'hFFFF, 0, 0);
        op("R7 config2 write in reset", 1, 6'd6, 16'hFFFF, 0, 0);
        op("R2 release ignores other bits", 1, 6'd0, 16'h032F, 0, 0);
        op("R7 config locked", 1, 6'd5, 16'h1234, 0, 0);
        op("R7 config2 locked", 1, 6'd6, 16'h0000, 0, 0);
        op("R3 rx enable", 1, 6'd0, 16'h0008, 0, 0);
        op("R3 both rx and timer pairs", 1, 6'd0, 16'h003C, 0, 0);
        op("R1 tx and load table", 1, 6'd0, 16'h0203, 0, 0);
        op("R11 engine done", 0, 6'd0, 16'h0, 16'hFFFF, 0);
        op("R8 tx ctl ro", 1, 6'd3, 16'hFFFF, 0, 0);
        op("R8 rx ctl ro", 1, 6'd4, 16'hFFFF, 0, 0);
        op("R6 mask top bit", 1, 6'd1, 16'hFFFF, 0, 0);
        op("R5 engine sets", 0, 6'd0, 16'h0, 0, 16'h00A0);
        op("R10 clear rsrc bit", 1, 6'd2, 16'h0020, 0, 0);
        op("R10 clear unset bit no strobe", 1, 6'd2, 16'h0020, 0, 0);
        op("R5 set wins over clear", 1, 6'd2, 16'h0080, 0, 16'h0080);
        op("R12 undefined write", 1, 6'd12, 16'hFFFF, 0, 0);
        op("R4 software reset", 1, 6'd0, 16'h0383, 0, 0);
        op("R9 eob writable", 1, 6'd7, 16'hABCD, 0, 0);

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [5:0]  a;
            logic [15:0] d, dn, ss;
            a  = 6'($urandom_range(0, 9));
            d  = 16'($urandom);
            if (a == 6'd0 && ($urandom_range(0, 3) != 0)) d[7] = 1'b0;
            dn = ($urandom_range(0, 4) == 0) ? 16'($urandom) : 16'h0;
            ss = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
            op("R1 R5 R7 random", 1'($urandom_range(0, 5) != 0), a, d, dn, ss);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule